// File: doc/BRIEF.md
# Rotate-Through-Flag Shifter Unit

This unit rotates a 32-bit operand through a single condition flag, so that the rotation runs over 33 bits. The flag sits logically below the operand's LSB. A left rotate by N pushes the old flag into result bit N-1, and the flag picks up the last operand bit that leaves the top. Negative amounts rotate right through the same 33-bit ring. The amount comes either from a signed immediate or from the signed low half of a second operand, and a wide register value is saturated into the legal range.

The flag is state held inside the unit, and a few flag-side operations let a caller drive it. A whole-status load takes the flag from one fixed bit of the loaded word. A bit test copies one selected operand bit into the flag, with an optional inversion. A signed less-than compare sets the flag from its result. A flag-gated move selects between a new value and the current destination value. Each operation is issued with a one-cycle strobe. The result word and the new flag appear on the following clock together with an output-valid pulse.

Operation codes on `op`: 0 status load, 1 rotate, 2 bit test, 3 signed compare, 4 conditional move, 5 to 7 reserved.

Top module: `rotflag_unit`

## Requirements
- R1: Status load (op 0): the flag becomes bit 5 of `src_a` (0x20 sets it, 0x00 clears it) and `out_data` equals `src_a`.
- R2: Rotate (op 1) by N in 1..31: `out_data` = {src_a[31-N:0], old flag, src_a[31:33-N]}, dropping the last field when N = 1, and the new flag is src_a[32-N]. Example: with the flag at 1, 0x62661557 by 1 gives 0xC4CC2AAF.
- R3: A rotate by 0 returns `src_a` unchanged and leaves the flag unchanged.
- R4: A negative amount N in -32..-1 rotates right by -N through the flag. This equals a left rotate by N+33, so -1 gives {old flag, src_a[31:1]} with the new flag src_a[0].
- R5: With `amt_from_reg` = 0 the amount is the 6-bit two's-complement `amt_imm`. With `amt_from_reg` = 1 it is src_b[15:0] read as signed and saturated to -32..31, and src_b[31:16] has no effect.
- R6: Bit test (op 2): the flag becomes src_a[bit_sel] XOR `bit_invert`, and `out_data` equals `src_a`.
- R7: Compare (op 3): the flag becomes 1 when `src_a` < `src_b` as signed 32-bit numbers and 0 otherwise, and `out_data` equals `src_a`.
- R8: Conditional move (op 4): `out_data` is `src_a` when the flag is 1 and `src_b` (the current destination value) when it is 0. The flag is unchanged.
- R9: Results appear one clock after an `in_valid` strobe, with `out_valid` high for exactly that cycle. In a cycle without `in_valid`, `out_data` and `out_flag` keep their values and `out_valid` is low.
- R10: During and right after reset, `out_valid`, `out_data` and `out_flag` are all 0.
- R11: Reserved codes 5 to 7 leave the flag unchanged and return `src_a` on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation code |
| src_a | input | 32 | Source operand / move source / status word |
| src_b | input | 32 | Compare operand, current destination value, or amount register |
| amt_imm | input | 6 | Signed immediate rotate amount |
| amt_from_reg | input | 1 | Take the amount from src_b[15:0] |
| bit_sel | input | 5 | Bit index for the bit test |
| bit_invert | input | 1 | Invert the tested bit |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_data | output | 32 | Result word |
| out_flag | output | 1 | Current condition flag |

## Verification
The hardest case to reach is a rotate whose amount lands on a range edge while the incoming flag is known. Such edges are +31, -32, 0, and register values that must saturate from far outside the range. Reaching them takes a flag-setting operation and then a rotate with a chosen amount source. The stimulus issues directed pairs: a status load or bit test to fix the flag, then a rotate at each edge amount from both the immediate and the register. Random operation streams then chain rotates back to back, so that each rotate's flag output feeds the next rotate. A serial one-bit-at-a-time model in the bench checks every result and every flag.

// File: rtl/rfu_pkg.sv
package rfu_pkg;
  typedef logic [2:0] op_t;
  localparam op_t OP_LOAD = 3'd0;
  localparam op_t OP_ROT  = 3'd1;
  localparam op_t OP_BTST = 3'd2;
  localparam op_t OP_LT   = 3'd3;
  localparam op_t OP_CMOV = 3'd4;

  typedef struct packed {
    logic        flag;
    logic [31:0] data;
  } res32_t;
endpackage

// File: rtl/rfu_amount.sv
// Selects the rotate amount, saturates a register-sourced value and folds
// negative amounts into an equivalent left rotate modulo W+1.
module rfu_amount #(
  parameter int W     = 32,
  parameter int SRC_W = 16
) (
  input  logic signed [$clog2(W):0]   imm,
  input  logic                        from_reg,
  input  logic signed [SRC_W-1:0]     reg_lo,
  output logic signed [$clog2(W):0]   amt,
  output logic [$clog2(W+1)-1:0]      k
);
  localparam int AW = $clog2(W) + 1;
  localparam int KW = $clog2(W + 1);
  localparam logic signed [SRC_W-1:0] HI = SRC_W'(W - 1);
  localparam logic signed [SRC_W-1:0] LO = SRC_W'(-W);

  function automatic logic signed [AW-1:0] clamp_amt(input logic signed [SRC_W-1:0] v);
    logic signed [AW-1:0] r;
    if (v > HI)      r = AW'(W - 1);
    else if (v < LO) r = AW'(-W);
    else             r = AW'(v);
    return r;
  endfunction

  function automatic logic [KW-1:0] wrap_amt(input logic signed [AW-1:0] a);
    logic signed [AW:0] e;
    e = {a[AW-1], a};
    if (a < 0) e = e + (AW+1)'(W + 1);
    return KW'(e);
  endfunction

  always_comb begin
    if (from_reg) amt = clamp_amt(reg_lo);
    else          amt = imm;
  end

  assign k = wrap_amt(amt);
endmodule

// File: rtl/rfu_rot33.sv
// Logarithmic left rotator over the W-bit operand with the flag as an
// extra bit below the LSB (W+1 bit ring).
module rfu_rot33 #(
  parameter int W = 32
) (
  input  logic [W-1:0]             din,
  input  logic                     fin,
  input  logic [$clog2(W+1)-1:0]   k,
  output logic [W-1:0]             dout,
  output logic                     fout
);
  localparam int KW = $clog2(W + 1);

  logic [W:0] ring [0:KW];

  assign ring[0] = {din, fin};

  generate
    for (genvar i = 0; i < KW; i++) begin : g_stage
      localparam int S = 1 << i;
      logic [W:0] rotated;
      assign rotated     = {ring[i][W-S:0], ring[i][W:W-S+1]};
      assign ring[i + 1] = k[i] ? rotated : ring[i];
    end
  endgenerate

  assign dout = ring[KW][W:1];
  assign fout = ring[KW][0];
endmodule

// File: rtl/rfu_flag_ops.sv
// Candidate flag values for the non-rotate flag setters.
module rfu_flag_ops #(
  parameter int W        = 32,
  parameter int FLAG_POS = 5
) (
  input  logic [W-1:0]          a,
  input  logic [W-1:0]          b,
  input  logic [$clog2(W)-1:0]  sel,
  input  logic                  inv,
  output logic                  load_flag,
  output logic                  test_flag,
  output logic                  less_flag
);
  function automatic logic signed_less(input logic [W-1:0] x, input logic [W-1:0] y);
    return $signed(x) < $signed(y);
  endfunction

  assign load_flag = a[FLAG_POS];
  assign test_flag = a[sel] ^ inv;
  assign less_flag = signed_less(a, b);
endmodule

// File: rtl/rotflag_unit.sv
module rotflag_unit #(
  parameter int W        = 32,
  parameter int SRC_W    = 16,
  parameter int FLAG_POS = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [2:0]            op,
  input  logic [W-1:0]          src_a,
  input  logic [W-1:0]          src_b,
  input  logic [$clog2(W):0]    amt_imm,
  input  logic                  amt_from_reg,
  input  logic [$clog2(W)-1:0]  bit_sel,
  input  logic                  bit_invert,
  output logic                  out_valid,
  output logic [W-1:0]          out_data,
  output logic                  out_flag
);
  import rfu_pkg::*;

  localparam int AW = $clog2(W) + 1;
  localparam int KW = $clog2(W + 1);

  logic signed [AW-1:0] amt_val;
  logic [KW-1:0]        rot_k;
  logic [W-1:0]         rot_data;
  logic                 rot_flag;
  logic                 load_flag, test_flag, less_flag;
  logic [W-1:0]         next_data;
  logic                 next_flag;

  rfu_amount #(.W(W), .SRC_W(SRC_W)) u_amount (
    .imm      (amt_imm),
    .from_reg (amt_from_reg),
    .reg_lo   (src_b[SRC_W-1:0]),
    .amt      (amt_val),
    .k        (rot_k)
  );

  rfu_rot33 #(.W(W)) u_rot (
    .din  (src_a),
    .fin  (out_flag),
    .k    (rot_k),
    .dout (rot_data),
    .fout (rot_flag)
  );

  rfu_flag_ops #(.W(W), .FLAG_POS(FLAG_POS)) u_flags (
    .a         (src_a),
    .b         (src_b),
    .sel       (bit_sel),
    .inv       (bit_invert),
    .load_flag (load_flag),
    .test_flag (test_flag),
    .less_flag (less_flag)
  );

  always_comb begin
    next_data = src_a;
    next_flag = out_flag;
    case (op_t'(op))
      OP_LOAD: next_flag = load_flag;
      OP_ROT: begin
        next_data = rot_data;
        next_flag = rot_flag;
      end
      OP_BTST: next_flag = test_flag;
      OP_LT:   next_flag = less_flag;
      OP_CMOV: next_data = out_flag ? src_a : src_b;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= next_data;
        out_flag <= next_flag;
      end
    end
  end
endmodule

// File: rtl/rotflag_unit_chk.sv
module rotflag_unit_chk #(
  parameter int W        = 32,
  parameter int FLAG_POS = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic [2:0]               op,
  input logic [W-1:0]             src_a,
  input logic [W-1:0]             src_b,
  input logic [$clog2(W)-1:0]     bit_sel,
  input logic                     bit_invert,
  input logic [$clog2(W+1)-1:0]   rot_k,
  input logic                     out_valid,
  input logic [W-1:0]             out_data,
  input logic                     out_flag
);
  localparam int IW = $clog2(W);

  logic          is_rot, rot_q, flag_q, top_q;
  logic [IW-1:0] slot_q, top_idx;

  assign is_rot  = in_valid && (op == 3'd1) && (rot_k != '0);
  assign top_idx = IW'(W - 32'(rot_k));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q  <= 1'b0;
      flag_q <= 1'b0;
      top_q  <= 1'b0;
      slot_q <= '0;
    end else begin
      rot_q  <= is_rot;
      flag_q <= out_flag;
      top_q  <= src_a[top_idx];
      slot_q <= IW'(rot_k - 1'b1);
    end
  end

  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_flag)));

  a_r1_load_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd0) |=> (out_flag == $past(src_a[FLAG_POS]) && out_data == $past(src_a)));

  a_r2_flag_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rot_q |-> (out_data[slot_q] == flag_q && out_flag == top_q));

  a_r3_zero_rot: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd1 && rot_k == '0) |=> (out_data == $past(src_a) && $stable(out_flag)));

  a_r6_bit_test: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd2) |=> (out_flag == $past(src_a[bit_sel] ^ bit_invert)));

  a_r7_signed_less: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd3) |=> (out_flag == $past($signed(src_a) < $signed(src_b))));

  a_r8_cmov_take: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd4 && out_flag) |=> (out_data == $past(src_a) && $stable(out_flag)));

  a_r8_cmov_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd4 && !out_flag) |=> (out_data == $past(src_b) && $stable(out_flag)));

  a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > 3'd4) |=> (out_data == $past(src_a) && $stable(out_flag)));
endmodule

bind rotflag_unit rotflag_unit_chk #(.W(W), .FLAG_POS(FLAG_POS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .op         (op),
  .src_a      (src_a),
  .src_b      (src_b),
  .bit_sel    (bit_sel),
  .bit_invert (bit_invert),
  .rot_k      (rot_k),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_flag   (out_flag)
);

// File: tb/rotflag_unit_tb.sv
module rotflag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [5:0]  amt_imm = '0;
  logic        amt_from_reg = 1'b0;
  logic [4:0]  bit_sel = '0;
  logic        bit_invert = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_flag;

  int n_chk = 0;
  int n_bad = 0;
  logic        m_flag = 1'b0;
  logic [31:0] m_data = '0;

  always #4 clk = ~clk;

  rotflag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .amt_imm(amt_imm),
    .amt_from_reg(amt_from_reg), .bit_sel(bit_sel), .bit_invert(bit_invert),
    .out_valid(out_valid), .out_data(out_data), .out_flag(out_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Effective amount as an integer in -32..31
  function automatic int eff_amt(input logic sel, input logic [5:0] imm, input logic [31:0] b);
    int v;
    if (!sel) return $signed(imm);
    v = $signed(b[15:0]);
    if (v > 31) v = 31;
    if (v < -32) v = -32;
    return v;
  endfunction

  // Serial ring model: right rotates step one bit down, left rotates one bit up
  function automatic logic [32:0] ring_rot(input logic [31:0] a, input logic f, input int n);
    logic [32:0] v;
    v = {a, f};
    if (n >= 0) for (int i = 0; i < n; i++) v = {v[31:0], v[32]};
    else        for (int i = 0; i < -n; i++) v = {v[0], v[32:1]};
    return v;
  endfunction

  task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [5:0] imm, input logic sel, input logic [4:0] idx,
                       input logic inv, input string req);
    logic [32:0] r;
    logic [31:0] ed;
    logic        ef;
    ed = a;
    ef = m_flag;
    case (o)
      3'd0: ef = a[5];
      3'd1: begin
        r  = ring_rot(a, m_flag, eff_amt(sel, imm, b));
        ed = r[32:1];
        ef = r[0];
      end
      3'd2: ef = a[idx] ^ inv;
      3'd3: ef = ($signed(a) < $signed(b));
      3'd4: ed = m_flag ? a : b;
      default: ;
    endcase
    op = o; src_a = a; src_b = b; amt_imm = imm; amt_from_reg = sel;
    bit_sel = idx; bit_invert = inv; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R9 valid"}, {31'd0, out_valid}, 32'd1);
    chk({req, " data"}, out_data, ed);
    chk({req, " flag"}, {31'd0, out_flag}, {31'd0, ef});
    m_flag = ef;
    m_data = ed;
  endtask

  task automatic idle();
    op = 3'($urandom); src_a = $urandom; src_b = $urandom; amt_imm = 6'($urandom);
    amt_from_reg = 1'($urandom); in_valid = 1'b0;
    @(negedge clk);
    chk("R9 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R9 idle data", out_data, m_data);
    chk("R9 idle flag", {31'd0, out_flag}, {31'd0, m_flag});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R10 reset data", out_data, 32'd0);
    chk("R10 reset flag", {31'd0, out_flag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 post-reset flag", {31'd0, out_flag}, 32'd0);

    // R1 / R2 directed vectors
    issue(3'd0, 32'h20, 0, 0, 0, 0, 0, "R1 load set");
    chk("R1 flag set", {31'd0, out_flag}, 32'd1);
    issue(3'd1, 32'h62661557, 0, 6'd1, 0, 0, 0, "R2 rot1 f1");
    chk("R2 literal", out_data, 32'hC4CC2AAF);
    issue(3'd0, 32'h0, 0, 0, 0, 0, 0, "R1 load clear");
    issue(3'd1, 32'h073B0007, 0, 6'd1, 0, 0, 0, "R2 rot1 f0");
    chk("R2 literal", out_data, 32'h0E76000E);
    issue(3'd0, 32'h20, 0, 0, 0, 0, 0, "R1 load");
    issue(3'd1, 32'h01F49088, 0, 6'd5, 0, 0, 0, "R2 rot5");
    chk("R2 literal", out_data, 32'h3E921110);
    issue(3'd1, 32'h3E921110, 32'hABCD_0002, 0, 1, 0, 0, "R5 reg amount 2");
    chk("R5 literal", out_data, 32'hFA484440);

    // R3 zero, R4 negative, R5 saturation
    issue(3'd2, 32'h1, 0, 0, 0, 5'd0, 0, "R6 set");
    issue(3'd1, 32'hDEADBEEF, 0, 6'd0, 0, 0, 0, "R3 zero imm");
    issue(3'd1, 32'h12345678, 32'hFFFF_0000, 0, 1, 0, 0, "R3 zero reg");
    issue(3'd1, 32'h80000001, 0, 6'h3F, 0, 0, 0, "R4 minus1");
    issue(3'd1, 32'h80000001, 0, 6'h20, 0, 0, 0, "R4 minus32");
    issue(3'd1, 32'hC0FFEE11, 0, 6'd31, 0, 0, 0, "R2 plus31");
    issue(3'd1, 32'hA5A5F00F, 32'h0000_7FFF, 0, 1, 0, 0, "R5 sat high");
    issue(3'd1, 32'hA5A5F00F, 32'hFFFF_8000, 0, 1, 0, 0, "R5 sat low");
    issue(3'd1, 32'h5A5A0FF0, 32'h1234_FFE0, 0, 1, 0, 0, "R5 exact -32");

    // R6, R7, R8, R11
    issue(3'd2, 32'h0000_0400, 0, 0, 0, 5'd10, 1, "R6 invert");
    issue(3'd2, 32'h8000_0000, 0, 0, 0, 5'd31, 0, "R6 msb");
    issue(3'd3, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0, "R7 neg<pos");
    issue(3'd3, 32'h1, 32'h8000_0000, 0, 0, 0, 0, "R7 pos<neg");
    issue(3'd4, 32'h1111_1111, 32'h2222_2222, 0, 0, 0, 0, "R8 keep");
    issue(3'd0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R1 load ones");
    issue(3'd4, 32'h1111_1111, 32'h2222_2222, 0, 0, 0, 0, "R8 take");
    issue(3'd6, 32'h3333_3333, 0, 0, 0, 0, 0, "R11 reserved");
    idle();

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] o;
      o = ($urandom % 3 == 0) ? 3'($urandom) : 3'd1;
      if ($urandom % 8 == 0) idle();
      issue(o, $urandom, $urandom, 6'($urandom), 1'($urandom), 5'($urandom),
            1'($urandom), "R2 R4 R5 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule